// File: doc/BRIEF.md
# Antenna Diversity Dwell Controller

This block runs a two-antenna diversity measurement. A start strobe begins a measurement window. The block holds antenna 0 for a programmed dwell time and then takes a received-signal-strength sample. It then switches to antenna 1, waits the same dwell time and takes a second sample. At the end of the window it records which antenna gave the stronger reading.

The dwell time is a 6-bit count of timebase steps. Each step lasts either 20 or 40 input clocks, chosen by a prescale mode input. In hardware mode the block drives the antenna select line: it follows the measurement while the window runs and shows the winner afterwards. In software mode the antenna line always follows a software select input. The timed dwells and the sample strobes still run, so software can collect RSSI readings and make the final choice itself.

Top module: `ant_div_ctrl`

## Requirements
- R1: After reset, with hardware mode enabled, `ant_o` is 0 and `rssi_stb_o` and `done_o` are 0.
- R2: One timebase step lasts 20 clocks when `presc_sel_i` is 0 and 40 clocks when it is 1. A dwell lasts `dwell_i` steps. If a start is accepted at clock edge E, the first sample strobe is high in the cycle after edge E+D·S and the second in the cycle after edge E+2·D·S, where D is the dwell count and S the step length.
- R3: When `dwell_i` is 0, a start strobe is ignored: no strobe, no done pulse, and `ant_o` does not change.
- R4: Each measurement gives exactly two one-cycle sample strobes. `rssi_ant_o` is 0 on the first and 1 on the second. Each strobe marks the RSSI value sampled at the clock edge that raised it.
- R5: In hardware mode during a measurement, `ant_o` is 0 during the first dwell and 1 during the second.
- R6: In hardware mode the final selection is antenna 1 only if the second sample is strictly greater than the first. A tie selects antenna 0. The selection holds on `ant_o` until the next measurement.
- R7: In software mode, `ant_o` equals `sw_ant_i` at all times, while dwells and strobes run as in R2 and R4.
- R8: `done_o` is a one-cycle pulse in the same cycle as the second strobe. The new selection is visible on `ant_o` from that cycle on.
- R9: A start strobe that arrives while a measurement is running is ignored.
- R10: `dwell_i` and `presc_sel_i` are captured when a start is accepted. Changing them during a measurement does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-measurement strobe |
| rssi_i | input | RSSI_W | Received signal strength value |
| dwell_i | input | DWELL_W | Dwell steps per antenna; 0 disables switching |
| presc_sel_i | input | 1 | Step length: 0 = 20 clocks, 1 = 40 clocks |
| hw_sel_en_i | input | 1 | 1 = internal antenna choice, 0 = software choice |
| sw_ant_i | input | 1 | Software antenna select |
| ant_o | output | 1 | Antenna select line |
| rssi_stb_o | output | 1 | RSSI sample strobe |
| rssi_ant_o | output | 1 | Antenna index of the current sample |
| done_o | output | 1 | One-cycle pulse when the measurement ends |

## Verification
A fault in the step or dwell counters moves the strobes by whole clocks. The scoreboard compares every strobe against its exact expected cycle, so such a fault is caught at the first sample of the first measurement. A fault in the stored first sample or in the comparison shows as the wrong antenna on `ant_o` in the very cycle `done_o` rises. A state machine that accepts a restart, or that misreads a zero dwell, produces extra or misplaced strobes, which the monitor flags in the cycle they appear.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DWELL0 = 2'd1,
    ST_DWELL1 = 2'd2
  } ad_state_e;
endpackage

// File: rtl/ant_div_prescaler.sv
module ant_div_prescaler #(
  parameter int unsigned STEP_LO = 20,
  parameter int unsigned STEP_HI = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(STEP_HI);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = long_i ? CW'(STEP_HI - 1) : CW'(STEP_LO - 1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ant_div_dwell_cnt.sv
module ant_div_dwell_cnt #(
  parameter int unsigned DWELL_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [DWELL_W-1:0] limit_i,
  output logic               expire_o
);
  logic [DWELL_W-1:0] step_q;

  assign expire_o = run_i && tick_i && (step_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (!run_i)    step_q <= '0;
    else if (expire_o)  step_q <= '0;
    else if (tick_i)    step_q <= step_q + 1'b1;
  end
endmodule

// File: rtl/ant_div_pick.sv
module ant_div_pick #(
  parameter int unsigned RSSI_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap0_i,
  input  logic              cap1_i,
  input  logic [RSSI_W-1:0] rssi_i,
  output logic [RSSI_W-1:0] rssi0_o,
  output logic              pick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rssi0_o <= '0;
      pick_o  <= 1'b0;
    end else begin
      if (cap0_i) rssi0_o <= rssi_i;
      // strict compare: ties stay on antenna 0
      if (cap1_i) pick_o  <= (rssi_i > rssi0_o);
    end
  end
endmodule

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl
  import ant_div_pkg::*;
#(
  parameter int unsigned RSSI_W  = 8,
  parameter int unsigned DWELL_W = 6,
  parameter int unsigned STEP_LO = 20,
  parameter int unsigned STEP_HI = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RSSI_W-1:0]  rssi_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               presc_sel_i,
  input  logic               hw_sel_en_i,
  input  logic               sw_ant_i,
  output logic               ant_o,
  output logic               rssi_stb_o,
  output logic               rssi_ant_o,
  output logic               done_o
);
  ad_state_e          state_q;
  logic [DWELL_W-1:0] dwell_q;
  logic               long_q;
  logic               stb_q, stb_ant_q, done_q;
  logic               busy, accept, tick, expire, pick;
  logic [RSSI_W-1:0]  rssi0;

  assign busy   = (state_q != ST_IDLE);
  assign accept = (state_q == ST_IDLE) && start_i && (dwell_i != '0);

  ant_div_prescaler #(.STEP_LO(STEP_LO), .STEP_HI(STEP_HI)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .long_i(long_q), .tick_o(tick)
  );

  ant_div_dwell_cnt #(.DWELL_W(DWELL_W)) u_dwell (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .tick_i(tick),
    .limit_i(dwell_q), .expire_o(expire)
  );

  ant_div_pick #(.RSSI_W(RSSI_W)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap0_i(state_q == ST_DWELL0 && expire),
    .cap1_i(state_q == ST_DWELL1 && expire),
    .rssi_i(rssi_i), .rssi0_o(rssi0), .pick_o(pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dwell_q   <= '0;
      long_q    <= 1'b0;
      stb_q     <= 1'b0;
      stb_ant_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      stb_q  <= busy && expire;
      done_q <= (state_q == ST_DWELL1) && expire;
      if (busy && expire) stb_ant_q <= (state_q == ST_DWELL1);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_DWELL0;
          dwell_q <= dwell_i;
          long_q  <= presc_sel_i;
        end
        ST_DWELL0: if (expire) state_q <= ST_DWELL1;
        ST_DWELL1: if (expire) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!hw_sel_en_i) ant_o = sw_ant_i;
    else if (busy)    ant_o = (state_q == ST_DWELL1);
    else              ant_o = pick;
  end

  assign rssi_stb_o = stb_q;
  assign rssi_ant_o = stb_ant_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ant_div_ctrl_chk.sv
module ant_div_ctrl_chk #(
  parameter int unsigned RSSI_W  = 8,
  parameter int unsigned DWELL_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [RSSI_W-1:0]  rssi_i,
  input logic [DWELL_W-1:0] dwell_i,
  input logic               hw_sel_en_i,
  input logic               ant_o,
  input logic               rssi_stb_o,
  input logic               rssi_ant_o,
  input logic               done_o,
  input logic               busy,
  input logic [RSSI_W-1:0]  rssi0
);
  assert_zero_dwell_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && dwell_i == '0) |=> !busy);

  assert_stb_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rssi_stb_o |=> !rssi_stb_o);

  assert_ant_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_sel_en_i && busy && rssi_stb_o && !rssi_ant_o) |-> ant_o);

  assert_hw_pick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hw_sel_en_i) |-> (ant_o == ($past(rssi_i) > rssi0)));

  assert_done_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rssi_stb_o && rssi_ant_o && !busy));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind ant_div_ctrl ant_div_ctrl_chk #(.RSSI_W(RSSI_W), .DWELL_W(DWELL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rssi_i(rssi_i),
  .dwell_i(dwell_i), .hw_sel_en_i(hw_sel_en_i), .ant_o(ant_o),
  .rssi_stb_o(rssi_stb_o), .rssi_ant_o(rssi_ant_o), .done_o(done_o),
  .busy(busy), .rssi0(rssi0)
);

// File: tb/ant_div_ctrl_tb_top.sv
module ant_div_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] rssi_i = '0;
  logic [5:0] dwell_i = '0;
  logic       presc_sel_i = 1'b0;
  logic       hw_sel_en_i = 1'b1;
  logic       sw_ant_i = 1'b0;
  logic       ant_o, rssi_stb_o, rssi_ant_o, done_o;

  int n_chk = 0, n_fail = 0, cyc = 0, stb_seen = 0;
  bit finished = 1'b0;

  typedef struct { int t; bit idx; bit last; bit sel; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  ant_div_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rssi_i(rssi_i),
    .dwell_i(dwell_i), .presc_sel_i(presc_sel_i), .hw_sel_en_i(hw_sel_en_i),
    .sw_ant_i(sw_ant_i), .ant_o(ant_o), .rssi_stb_o(rssi_stb_o),
    .rssi_ant_o(rssi_ant_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected strobes
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (rssi_stb_o) begin
        stb_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.t, "R2 strobe cycle", cyc, e.t);
          chk(rssi_ant_o == e.idx, "R4 strobe index", rssi_ant_o, e.idx);
          chk(done_o == e.last, "R8 done with last strobe", done_o, e.last);
          if (e.last) chk(ant_o == e.sel, "R6 R7 selection at done", ant_o, e.sel);
        end
      end else if (done_o) chk(1'b0, "R8 done without strobe", 1, 0);
    end
  end

  // driver: one measurement, pushes expected strobes
  task automatic run_meas(input int d, input bit lg, input bit hw, input bit sw,
                          input int r0, input int r1, input bit poke);
    int c, p, t1, t2;
    bit sel;
    @(negedge clk_i);
    dwell_i = 6'(d); presc_sel_i = lg; hw_sel_en_i = hw; sw_ant_i = sw;
    rssi_i = 8'(r0); start_i = 1'b1;
    c = cyc; p = lg ? 40 : 20;
    t1 = c + 1 + d * p; t2 = c + 1 + 2 * d * p;
    sel = hw ? (r1 > r0) : sw;
    exp_q.push_back('{t1, 1'b0, 1'b0, 1'b0});
    exp_q.push_back('{t2, 1'b1, 1'b1, sel});
    @(negedge clk_i);
    start_i = 1'b0;
    if (hw) chk(ant_o == 1'b0, "R5 antenna 0 in first dwell", ant_o, 0);
    else    chk(ant_o == sw, "R7 software antenna", ant_o, sw);
    if (poke) begin
      // R9 restart while busy, R10 config change mid-run
      start_i = 1'b1; dwell_i = 6'(d + 3); presc_sel_i = ~lg;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (cyc < t1) @(negedge clk_i);
    rssi_i = 8'(r1);
    @(negedge clk_i);
    if (hw) chk(ant_o == 1'b1, "R5 antenna 1 in second dwell", ant_o, 1);
    else    chk(ant_o == sw, "R7 software antenna mid-run", ant_o, sw);
    while (cyc < t2 + 1) @(negedge clk_i);
    dwell_i = 6'(d); presc_sel_i = lg;
    chk(ant_o == sel, "R6 R7 selection held", ant_o, sel);
    chk(exp_q.size() == 0, "R4 two strobes per run", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", cyc, 200000);
    finish_run();
  end

  initial begin
    int s0;
    bit a0;
    repeat (3) @(negedge clk_i);
    chk(ant_o == 1'b0 && rssi_stb_o == 1'b0 && done_o == 1'b0, "R1 reset outputs",
        {ant_o, rssi_stb_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ant_o == 1'b0, "R1 antenna after reset", ant_o, 0);

    run_meas(3, 1'b0, 1'b1, 1'b0, 10, 50, 1'b0);   // R6 antenna 1 wins
    run_meas(1, 1'b0, 1'b1, 1'b0, 33, 33, 1'b0);   // R6 tie keeps 0
    run_meas(2, 1'b1, 1'b1, 1'b0, 80, 20, 1'b0);   // R2 40-clock step
    run_meas(4, 1'b1, 1'b0, 1'b0, 5, 90, 1'b0);    // R7 software wins over stronger antenna 1
    @(negedge clk_i);
    sw_ant_i = 1'b1;
    @(negedge clk_i);
    chk(ant_o == 1'b1, "R7 follows software select", ant_o, 1);
    run_meas(5, 1'b0, 1'b1, 1'b0, 100, 101, 1'b1); // R9 R10
    run_meas(63, 1'b1, 1'b1, 1'b0, 0, 255, 1'b0);  // R2 max dwell

    // R3 zero dwell: no run
    a0 = ant_o; s0 = stb_seen;
    @(negedge clk_i);
    dwell_i = '0; start_i = 1'b1; rssi_i = 8'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (100) @(negedge clk_i);
    chk(stb_seen == s0, "R3 no strobe with zero dwell", stb_seen, s0);
    chk(ant_o == a0, "R3 antenna unchanged", ant_o, a0);
    chk(exp_q.size() == 0, "R3 queue empty", exp_q.size(), 0);
    finish_run();
  end
endmodule